// File: doc/BRIEF.md
# Twelve-Bit Word to Sector Byte Packer

This block sits between a word-oriented memory port and a byte-oriented disk sector stream. On a disk write it takes 12-bit memory words and turns them into sector bytes. On a disk read it takes sector bytes and rebuilds memory words. A mode pin selects one of two formats. In packed mode every two 12-bit words share three bytes. In narrow mode each word carries a single byte in its low eight bits.

A transfer starts with a one-cycle `start` pulse. At that moment the block latches the direction, the mode, a two's-complement word count, a 15-bit memory address and the starting sector. From these it works out how many words and bytes the transfer really moves. A packed transfer is capped at one 256-byte sector. A narrow transfer is capped at the end of the 40-sector track.

During the transfer the block steps the memory address and the word count. A write is padded with zero bytes up to the next sector boundary. When a read runs out of source bytes, the missing bytes count as zero. When the transfer ends, `done` pulses and `incomplete` reports whether the word count failed to reach zero.

Top module: `word_byte_packer`

## Requirements
- R1: After reset `busy`, `done`, `incomplete`, `by_out_valid` and `wd_out_valid` are 0, and `mem_addr` and `wc_now` are 0.
- R2: The requested length is 4096 minus `wc_in`, so a `wc_in` of 0 requests 4096 words. `wc_now` starts at `wc_in` and rises by one for every word moved. At the end it equals `wc_in` plus the words moved, modulo 4096.
- R3: On a packed write, words are taken in pairs (even word E, odd word O) and sent as three bytes in this order: E[7:0], then {O[3:0], E[11:8]}, then O[11:4].
- R4: On a packed read, every three bytes B0, B1, B2 produce the even word {B1[3:0], B0} and then the odd word {B2, B1[7:4]}.
- R5: In packed mode the byte count is (3n+1)/2 for n requested words. If that count exceeds 256, the transfer moves 170 words and 256 bytes. On a read the block consumes exactly that byte count, so the unused last byte is consumed but produces no word.
- R6: In narrow mode (`mode_8b`=1) a write sends each word's bits 7:0. A read returns each byte as a word whose bits 11:8 are zero.
- R7: In narrow mode the words moved are the smaller of n and (40 − `sector_in`)×256. A `sector_in` of 40 or more moves nothing.
- R8: A write emits zero bytes after its last data byte up to the next multiple of 256 bytes. A packed write therefore always emits exactly 256 bytes.
- R9: `mem_addr[11:0]` rises by one for every word moved and wraps from 4095 to 0. `mem_addr[14:12]` holds the value loaded at start.
- R10: On a read, while `by_in_end` is high and `by_in_valid` is low, the next byte is taken as 0 without a handshake.
- R11: One cycle after the last byte or word of a transfer completes, the block enters its finish cycle. `done` is 1 in that cycle only. During that cycle `incomplete` becomes 1 if `wc_now` is not 0, and it then holds that value until the next start.
- R12: A `start` pulse while `busy` is high is ignored and does not change the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a transfer when idle |
| write_dir | input | 1 | 1: words to bytes (write), 0: bytes to words (read) |
| mode_8b | input | 1 | 1: narrow one-byte-per-word mode, 0: packed mode |
| wc_in | input | 12 | Two's-complement word count |
| ma_in | input | 15 | Start address: extension field in 14:12, word address in 11:0 |
| sector_in | input | 6 | Starting sector, used by the narrow-mode limit |
| wd_in_valid | input | 1 | Write word available |
| wd_in_ready | output | 1 | Write word taken |
| wd_in_data | input | 12 | Write word |
| wd_out_valid | output | 1 | Read word available |
| wd_out_ready | input | 1 | Read word accepted |
| wd_out_data | output | 12 | Read word |
| by_out_valid | output | 1 | Sector byte available (write) |
| by_out_ready | input | 1 | Sector byte accepted |
| by_out_data | output | 8 | Sector byte (write) |
| by_in_valid | input | 1 | Sector byte available (read) |
| by_in_ready | output | 1 | Sector byte taken |
| by_in_data | input | 8 | Sector byte (read) |
| by_in_end | input | 1 | No more source bytes; substitute zeros |
| mem_addr | output | 15 | Current memory word address |
| wc_now | output | 12 | Current word count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| incomplete | output | 1 | Final word count was not zero |

## Verification
A wrong phase counter or nibble holding register shows up on the very next output byte or word. It appears as a nibble swapped or shifted out of place, so the byte-by-byte scoreboard catches it within three bytes of the fault. A wrong sizing result changes how many bytes come out or go in, which shows up as a missing or extra stream item, and it also changes `wc_now` and `incomplete` in the finish cycle. A wrong address or count step shows in `mem_addr` and `wc_now` one cycle after the word handshake, and it is checked when `done` is high.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  localparam int WORD_W = 12;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int CNT_W  = 16;

  typedef enum logic [1:0] {PH0 = 2'd0, PH1 = 2'd1, PH2 = 2'd2} phase_t;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_FIN = 2'd2} state_t;

  typedef struct packed {
    logic [CNT_W-1:0] words;
    logic [CNT_W-1:0] bytes;
    logic [CNT_W-1:0] emit;
  } size_t;

  function automatic phase_t next_phase(input phase_t p);
    case (p)
      PH0:     return PH1;
      PH1:     return PH2;
      default: return PH0;
    endcase
  endfunction

  function automatic int true_len(input logic [WORD_W-1:0] wc);
    return (1 << WORD_W) - int'(wc);
  endfunction
endpackage

// File: rtl/wbp_track.sv
module wbp_track
  import wbp_pkg::*;
#(
  parameter int EXT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [EXT_W-1:0]        ext_in,
  input  logic [WORD_W-1:0]       lo_in,
  input  logic [WORD_W-1:0]       wc_in,
  input  logic                    step,
  output logic [EXT_W+WORD_W-1:0] addr,
  output logic [WORD_W-1:0]       wc_cur
);
  logic [EXT_W-1:0]  ext_q;
  logic [WORD_W-1:0] lo_q;
  logic [WORD_W-1:0] wc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= '0;
      lo_q  <= '0;
      wc_q  <= '0;
    end else if (load) begin
      ext_q <= ext_in;
      lo_q  <= lo_in;
      wc_q  <= wc_in;
    end else if (step) begin
      lo_q <= lo_q + 1'b1;
      wc_q <= wc_q + 1'b1;
    end
  end

  assign addr   = {ext_q, lo_q};
  assign wc_cur = wc_q;
endmodule

// File: rtl/wbp_pack.sv
module wbp_pack
  import wbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              mode8,
  input  logic [CNT_W-1:0]  words_ld,
  input  logic [CNT_W-1:0]  bytes_ld,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [WORD_W-1:0] w_data,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [BYTE_W-1:0] b_data,
  output logic              busy,
  output logic              word_step
);
  logic [CNT_W-1:0]  words_left, bytes_left;
  phase_t            phase;
  logic              mode8_q;
  logic [NIB_W-1:0]  hold_lo;
  logic [BYTE_W-1:0] hold_hi;
  logic              need_word;
  logic              byte_step;
  logic [WORD_W-1:0] wd;

  assign busy      = (bytes_left != '0);
  assign need_word = busy && (words_left != '0) && (mode8_q || phase != PH2);
  assign b_valid   = busy && (!need_word || w_valid);
  assign w_ready   = need_word && b_ready;
  assign byte_step = b_valid && b_ready;
  assign word_step = byte_step && need_word;
  assign wd        = need_word ? w_data : '0;

  always_comb begin
    if (mode8_q) b_data = wd[BYTE_W-1:0];
    else begin
      case (phase)
        PH0:     b_data = wd[BYTE_W-1:0];
        PH1:     b_data = {wd[NIB_W-1:0], hold_lo};
        default: b_data = hold_hi;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_left <= '0;
      bytes_left <= '0;
      phase      <= PH0;
      mode8_q    <= 1'b0;
      hold_lo    <= '0;
      hold_hi    <= '0;
    end else if (load) begin
      words_left <= words_ld;
      bytes_left <= bytes_ld;
      phase      <= PH0;
      mode8_q    <= mode8;
      hold_lo    <= '0;
      hold_hi    <= '0;
    end else if (byte_step) begin
      bytes_left <= bytes_left - 1'b1;
      if (need_word) words_left <= words_left - 1'b1;
      if (!mode8_q) begin
        phase <= next_phase(phase);
        if (phase == PH0) hold_lo <= wd[WORD_W-1:BYTE_W];
        if (phase == PH1) hold_hi <= wd[WORD_W-1:NIB_W];
      end
    end
  end

  AST_WORD_RIDES_BYTE: assert property (@(posedge clk) disable iff (!rst_n) (w_valid && w_ready) |-> (b_valid && b_ready)); // R3
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (b_valid && words_left == '0 && phase == PH0) |-> (b_data == '0)); // R8
endmodule

// File: rtl/wbp_unpack.sv
module wbp_unpack
  import wbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              mode8,
  input  logic [CNT_W-1:0]  words_ld,
  input  logic [CNT_W-1:0]  bytes_ld,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic [BYTE_W-1:0] b_data,
  input  logic              b_end,
  output logic              w_valid,
  input  logic              w_ready,
  output logic [WORD_W-1:0] w_data,
  output logic              busy,
  output logic              word_step
);
  logic [CNT_W-1:0]  words_left, bytes_left;
  phase_t            phase;
  logic              mode8_q;
  logic [BYTE_W-1:0] hold;
  logic              have_byte, emit, byte_step;
  logic [BYTE_W-1:0] bd;

  assign busy      = (bytes_left != '0);
  assign have_byte = b_valid || b_end;
  assign bd        = b_valid ? b_data : '0;
  assign emit      = busy && (words_left != '0) && (mode8_q || phase != PH0);
  assign w_valid   = emit && have_byte;
  assign b_ready   = busy && (!emit || w_ready);
  assign byte_step = busy && have_byte && (!emit || w_ready);
  assign word_step = byte_step && emit;

  always_comb begin
    if (mode8_q) w_data = {{NIB_W{1'b0}}, bd};
    else begin
      case (phase)
        PH1:     w_data = {bd[NIB_W-1:0], hold};
        PH2:     w_data = {bd, hold[NIB_W-1:0]};
        default: w_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_left <= '0;
      bytes_left <= '0;
      phase      <= PH0;
      mode8_q    <= 1'b0;
      hold       <= '0;
    end else if (load) begin
      words_left <= words_ld;
      bytes_left <= bytes_ld;
      phase      <= PH0;
      mode8_q    <= mode8;
      hold       <= '0;
    end else if (byte_step) begin
      bytes_left <= bytes_left - 1'b1;
      if (emit) words_left <= words_left - 1'b1;
      if (!mode8_q) begin
        phase <= next_phase(phase);
        if (phase == PH0) hold <= bd;
        if (phase == PH1) hold <= {{NIB_W{1'b0}}, bd[BYTE_W-1:NIB_W]};
      end
    end
  end

  AST_HI_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (w_valid && mode8_q) |-> (w_data[WORD_W-1:BYTE_W] == '0)); // R6
  AST_WORD_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n) (w_valid && w_ready) |-> (b_valid || b_end)); // R10
endmodule

// File: rtl/word_byte_packer.sv
module word_byte_packer
  import wbp_pkg::*;
#(
  parameter int SECT_BYTES  = 256,
  parameter int TRACK_SECTS = 40,
  parameter int EXT_W       = 3,
  parameter int SECT_W      = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    write_dir,
  input  logic                    mode_8b,
  input  logic [WORD_W-1:0]       wc_in,
  input  logic [EXT_W+WORD_W-1:0] ma_in,
  input  logic [SECT_W-1:0]       sector_in,
  input  logic                    wd_in_valid,
  output logic                    wd_in_ready,
  input  logic [WORD_W-1:0]       wd_in_data,
  output logic                    wd_out_valid,
  input  logic                    wd_out_ready,
  output logic [WORD_W-1:0]       wd_out_data,
  output logic                    by_out_valid,
  input  logic                    by_out_ready,
  output logic [BYTE_W-1:0]       by_out_data,
  input  logic                    by_in_valid,
  output logic                    by_in_ready,
  input  logic [BYTE_W-1:0]       by_in_data,
  input  logic                    by_in_end,
  output logic [EXT_W+WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0]       wc_now,
  output logic                    busy,
  output logic                    done,
  output logic                    incomplete
);
  localparam int ADDR_W     = EXT_W + WORD_W;
  localparam int PACKED_MAX = (SECT_BYTES * 2) / 3;

  function automatic size_t size_xfer(input logic m8, input logic [WORD_W-1:0] wc,
                                      input logic [SECT_W-1:0] sect);
    int n, bc, room, emit;
    size_t s;
    n = true_len(wc);
    if (!m8) begin
      bc = (n * 3 + 1) / 2;
      if (bc > SECT_BYTES) begin
        bc = SECT_BYTES;
        n  = PACKED_MAX;
      end
    end else begin
      room = (int'(sect) < TRACK_SECTS) ? (TRACK_SECTS - int'(sect)) * SECT_BYTES : 0;
      if (n > room) n = room;
      bc = n;
    end
    emit    = ((bc + SECT_BYTES - 1) / SECT_BYTES) * SECT_BYTES;
    s.words = CNT_W'(n);
    s.bytes = CNT_W'(bc);
    s.emit  = CNT_W'(emit);
    return s;
  endfunction

  state_t state_q;
  logic   dir_q;
  logic   incomplete_q;
  logic   load, load_wr, load_rd;
  size_t  sz;
  logic   pk_busy, up_busy, eng_busy;
  logic   pk_step, up_step, word_step;

  assign load    = start && (state_q == ST_IDLE);
  assign load_wr = load && write_dir;
  assign load_rd = load && !write_dir;
  assign sz      = size_xfer(mode_8b, wc_in, sector_in);

  wbp_pack u_pack (
    .clk(clk), .rst_n(rst_n), .load(load_wr), .mode8(mode_8b),
    .words_ld(sz.words), .bytes_ld(sz.emit),
    .w_valid(wd_in_valid), .w_ready(wd_in_ready), .w_data(wd_in_data),
    .b_valid(by_out_valid), .b_ready(by_out_ready), .b_data(by_out_data),
    .busy(pk_busy), .word_step(pk_step)
  );

  wbp_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .load(load_rd), .mode8(mode_8b),
    .words_ld(sz.words), .bytes_ld(sz.bytes),
    .b_valid(by_in_valid), .b_ready(by_in_ready), .b_data(by_in_data), .b_end(by_in_end),
    .w_valid(wd_out_valid), .w_ready(wd_out_ready), .w_data(wd_out_data),
    .busy(up_busy), .word_step(up_step)
  );

  assign word_step = pk_step || up_step;
  assign eng_busy  = dir_q ? pk_busy : up_busy;

  wbp_track #(.EXT_W(EXT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .load(load),
    .ext_in(ma_in[ADDR_W-1:WORD_W]), .lo_in(ma_in[WORD_W-1:0]), .wc_in(wc_in),
    .step(word_step), .addr(mem_addr), .wc_cur(wc_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      dir_q        <= 1'b0;
      incomplete_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (load) begin
          state_q      <= ST_RUN;
          dir_q        <= write_dir;
          incomplete_q <= 1'b0;
        end
        ST_RUN: if (!eng_busy) begin
          state_q      <= ST_FIN;
          incomplete_q <= (wc_now != '0);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_FIN);
  assign incomplete = incomplete_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_WC_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_RUN && word_step) |=> (wc_now == $past(wc_now) + 1'b1)); // R2
  AST_EXT_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_RUN) |=> $stable(mem_addr[ADDR_W-1:WORD_W])); // R9
  AST_NO_DUAL_STREAM: assert property (@(posedge clk) disable iff (!rst_n) !(by_out_valid && wd_out_valid)); // R12
endmodule

// File: tb/word_byte_packer_tb.sv
module word_byte_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, write_dir = 1'b0, mode_8b = 1'b0;
  logic [11:0] wc_in = '0;
  logic [14:0] ma_in = '0;
  logic [5:0]  sector_in = '0;
  logic        wd_in_valid, wd_in_ready;
  logic [11:0] wd_in_data;
  logic        wd_out_valid;
  logic        wd_out_ready = 1'b0;
  logic [11:0] wd_out_data;
  logic        by_out_valid;
  logic        by_out_ready = 1'b0;
  logic [7:0]  by_out_data;
  logic        by_in_valid, by_in_ready, by_in_end;
  logic [7:0]  by_in_data;
  logic [14:0] mem_addr;
  logic [11:0] wc_now;
  logic        busy, done, incomplete;

  int n_checks = 0, n_fails = 0, cyc = 0;
  int seed = 0, widx = 0, bidx = 0, avail = 0;
  bit src_w_on = 0, src_b_on = 0, stall = 0;
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  word_byte_packer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .write_dir(write_dir), .mode_8b(mode_8b),
    .wc_in(wc_in), .ma_in(ma_in), .sector_in(sector_in),
    .wd_in_valid(wd_in_valid), .wd_in_ready(wd_in_ready), .wd_in_data(wd_in_data),
    .wd_out_valid(wd_out_valid), .wd_out_ready(wd_out_ready), .wd_out_data(wd_out_data),
    .by_out_valid(by_out_valid), .by_out_ready(by_out_ready), .by_out_data(by_out_data),
    .by_in_valid(by_in_valid), .by_in_ready(by_in_ready), .by_in_data(by_in_data),
    .by_in_end(by_in_end), .mem_addr(mem_addr), .wc_now(wc_now),
    .busy(busy), .done(done), .incomplete(incomplete)
  );

  function automatic logic [11:0] wgen(int s, int i);
    return 12'((i * 1237 + s * 911 + 7) ^ (i << 5));
  endfunction
  function automatic logic [7:0] bgen(int s, int i);
    return 8'((i * 73 + s * 29 + 3) ^ (i >> 2));
  endfunction

  assign wd_in_valid = src_w_on;
  assign wd_in_data  = wgen(seed, widx);
  assign by_in_valid = src_b_on && (bidx < avail);
  assign by_in_end   = src_b_on && (bidx >= avail);
  assign by_in_data  = bgen(seed, bidx);

  task automatic check(bit ok, string tag, int act, int exp, string what);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor and sources: sample at negedge, advance just after posedge
  initial begin
    forever begin
      bit hw, hb;
      @(negedge clk);
      hw = wd_in_valid && wd_in_ready;
      hb = by_in_valid && by_in_ready || (by_in_end && busy && by_in_ready);
      if (by_out_valid && by_out_ready) begin
        if (exp_q.size() == 0) check(0, "R8", by_out_data, 0, "extra byte");
        else begin
          int e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(by_out_data == 8'(e), t, by_out_data, e, "byte");
        end
      end
      if (wd_out_valid && wd_out_ready) begin
        if (exp_q.size() == 0) check(0, "R4", wd_out_data, 0, "extra word");
        else begin
          int e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(wd_out_data == 12'(e), t, wd_out_data, e, "word");
        end
      end
      @(posedge clk);
      #1;
      cyc++;
      if (hw) widx++;
      if (hb) bidx++;
      by_out_ready = !stall || (cyc % 3 != 1);
      wd_out_ready = !stall || (cyc % 4 != 2);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL R11 watchdog expired: actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic finish_checks(int wc, int ext, int lo, int n_eff, string tag);
    int t = 0;
    int exp_wc;
    do begin @(negedge clk); #1; t++; end while (!done && t < 20000);
    check(done == 1'b1, "R11", done, 1, "done seen");
    exp_wc = (wc + n_eff) & 4095;
    check(exp_q.size() == 0, tag, exp_q.size(), 0, "items left");
    check(wc_now == 12'(exp_wc), "R2", wc_now, exp_wc, "final count");
    check(mem_addr == 15'((ext << 12) | ((lo + n_eff) & 4095)), "R9", mem_addr,
          (ext << 12) | ((lo + n_eff) & 4095), "final address");
    check(incomplete == (exp_wc != 0), "R11", incomplete, exp_wc != 0, "incomplete");
    @(negedge clk); #1;
    check(done == 1'b0, "R11", done, 0, "done one cycle");
    exp_q.delete(); tag_q.delete();
  endtask

  task automatic run_write(bit m8, int n_req, int ext, int lo, int sect, int sd,
                           bit st, bit intrude);
    int wc, n, bc, emit, room;
    wc = (4096 - n_req) & 4095;
    n  = (wc == 0) ? 4096 : 4096 - wc;
    if (!m8) begin
      if (n > 170) n = 170;
      bc = n + (n + 1) / 2;
      emit = 256;
      for (int g = 0; g < 86; g++) begin
        logic [11:0] w0, w1;
        logic [23:0] grp;
        w0 = (2 * g < n) ? wgen(sd, 2 * g) : 12'h0;
        w1 = (2 * g + 1 < n) ? wgen(sd, 2 * g + 1) : 12'h0;
        grp = {w1, w0};
        for (int k = 0; k < 3; k++)
          if (3 * g + k < emit) begin
            exp_q.push_back(int'(grp[8*k +: 8]));
            tag_q.push_back((3 * g + k < bc) ? "R3" : "R8");
          end
      end
    end else begin
      room = (sect >= 40) ? 0 : (40 - sect) * 256;
      if (n > room) n = room;
      bc = n;
      emit = ((bc + 255) / 256) * 256;
      for (int k = 0; k < emit; k++) begin
        exp_q.push_back((k < n) ? int'(wgen(sd, k) & 12'hFF) : 0);
        tag_q.push_back((k < n) ? "R6" : "R8");
      end
    end
    seed = sd; widx = 0; stall = st; src_w_on = 1;
    write_dir = 1; mode_8b = m8; wc_in = 12'(wc); ma_in = 15'((ext << 12) | lo);
    sector_in = 6'(sect);
    pulse_start();
    if (intrude) begin
      repeat (5) @(posedge clk);
      #1 start = 1; write_dir = 0; mode_8b = ~m8; wc_in = 12'd4095; ma_in = '0;
      @(posedge clk); #1 start = 0; write_dir = 1; mode_8b = m8; wc_in = 12'(wc);
      ma_in = 15'((ext << 12) | lo);
    end
    finish_checks(wc, ext, lo, n, intrude ? "R12" : (m8 ? "R7" : "R5"));
    check(widx == n, m8 ? "R7" : "R5", widx, n, "words taken");
    src_w_on = 0;
  endtask

  task automatic run_read(bit m8, int n_req, int ext, int lo, int sect, int sd,
                          int av, bit st);
    int wc, n, bc, room;
    wc = (4096 - n_req) & 4095;
    n  = (wc == 0) ? 4096 : 4096 - wc;
    if (!m8) begin
      if (n > 170) begin n = 170; bc = 256; end
      else bc = n + (n + 1) / 2;
      for (int i = 0; i < n; i++) begin
        int g, b0, b1, b2;
        g  = i / 2;
        b0 = (3 * g < av) ? int'(bgen(sd, 3 * g)) : 0;
        b1 = (3 * g + 1 < av) ? int'(bgen(sd, 3 * g + 1)) : 0;
        b2 = (3 * g + 2 < av) ? int'(bgen(sd, 3 * g + 2)) : 0;
        if (i % 2 == 0) exp_q.push_back(((b1 & 15) << 8) | b0);
        else exp_q.push_back((b2 << 4) | (b1 >> 4));
        tag_q.push_back((av < bc) ? "R10" : "R4");
      end
    end else begin
      room = (sect >= 40) ? 0 : (40 - sect) * 256;
      if (n > room) n = room;
      bc = n;
      for (int k = 0; k < n; k++) begin
        exp_q.push_back((k < av) ? int'(bgen(sd, k)) : 0);
        tag_q.push_back((av < bc) ? "R10" : "R6");
      end
    end
    seed = sd; bidx = 0; avail = av; stall = st; src_b_on = 1;
    write_dir = 0; mode_8b = m8; wc_in = 12'(wc); ma_in = 15'((ext << 12) | lo);
    sector_in = 6'(sect);
    pulse_start();
    finish_checks(wc, ext, lo, n, "R4");
    check(bidx == bc, "R5", bidx, bc, "bytes consumed");
    src_b_on = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && incomplete == 0, "R1", {busy, done, incomplete}, 0, "flags");
    check(by_out_valid == 0 && wd_out_valid == 0, "R1", {by_out_valid, wd_out_valid}, 0, "valids");
    check(mem_addr == 0 && wc_now == 0, "R1", mem_addr, 0, "address/count");
    run_write(0, 2, 2, 100, 0, 1, 0, 0);        // R3 R8 pair packing
    run_write(0, 3, 1, 7, 0, 2, 1, 0);          // R3 odd count with stalls
    run_write(0, 200, 0, 4000, 0, 3, 0, 0);     // R5 cap, wraps R9, incomplete R11
    run_write(0, 4096, 3, 0, 0, 4, 1, 0);       // R2 zero count means 4096
    run_read(0, 4, 0, 10, 0, 5, 6, 0);          // R4
    run_read(0, 171, 6, 50, 0, 6, 256, 1);      // R5 unused byte consumed
    run_read(0, 2, 0, 0, 0, 7, 2, 0);           // R10 missing byte zero
    run_write(1, 5, 5, 4093, 0, 8, 0, 0);       // R6 R8 R9 wrap
    run_read(1, 3, 4, 20, 0, 9, 3, 1);          // R6
    run_write(1, 300, 7, 4094, 39, 10, 0, 0);   // R7 last sector
    run_write(1, 9, 0, 0, 40, 11, 0, 0);        // R7 past the track
    run_write(1, 4096, 0, 0, 0, 12, 1, 0);      // R2 R8 full narrow run
    run_write(0, 4, 2, 300, 0, 13, 0, 1);       // R12 start while busy
    run_read(1, 3, 0, 0, 0, 14, 1, 0);          // R10 narrow
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule